// File: doc/BRIEF.md
# Paged Address Translator with Ring Protection

This block turns a 16-bit virtual word address into an 18-bit physical word address. Memory is split into 1K-word pages. The low ten address bits pass straight through. The six upper bits, together with a 2-bit table select, pick one entry from a 256-entry on-chip table. That table holds four separate 64-entry page tables. The entry supplies an 8-bit physical page number, three permission bits and a ring number.

Every lookup is checked in two ways. First, the access kind (data read, data write or instruction fetch) must be allowed by the entry's permission bits. Second, the requesting ring must be at least the page's ring. If either check fails, the block raises a protection fault. An entry whose valid bit is clear raises a page fault instead. Either fault asserts the request line for the level-14 status interrupt. Software loads the table through a single synchronous write port.

The table is read combinationally. The translated result is registered at the end of the cycle that presents the address, so the lookup adds no wait states.

Top module: `mmu_ring_xlate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rsp_valid, rsp_paddr, fault_page, fault_prot and irq_lvl14 are all zero.
- R2: A write with tbl_we high stores tbl_wdata at tbl_waddr = {table select, virtual page}. The entry layout is: bits [7:0] physical page, bit 8 read permit, bit 9 write permit, bit 10 fetch permit, bits [12:11] page ring, bit 13 valid.
- R3: One cycle after a request with req_valid high, rsp_valid is high. On success, rsp_paddr = {entry page, req_vaddr[9:0]}.
- R4: req_tsel selects which of the four tables is used, so the same virtual address under different selects yields each table's own mapping.
- R5: An entry with its valid bit clear gives fault_page=1, fault_prot=0 and rsp_paddr=0, whatever the ring and the access kind.
- R6: If req_ring is lower than the page ring, the result is fault_prot=1 and rsp_paddr=0. If req_ring is equal to or higher than the page ring, the ring check passes.
- R7: req_kind 0 (read) needs bit 8, 1 (write) needs bit 9, and 2 (fetch) needs bit 10. When the needed bit is clear, fault_prot is set. Kind 3 always gives fault_prot.
- R8: irq_lvl14 is high exactly in the cycles where fault_page or fault_prot is high, and the two faults are never high together.
- R9: One cycle after req_valid is low, rsp_valid, both faults, irq_lvl14 and rsp_paddr are all zero.
- R10: A lookup in the same cycle as a write to the same entry uses the entry's previous contents. The next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 16 | Virtual word address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| req_ring | input | 2 | Ring of the requesting program |
| req_tsel | input | 2 | Page table select |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 8 | Table entry address {select, virtual page} |
| tbl_wdata | input | 14 | Table entry data |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_paddr | output | 18 | Physical word address, zero on fault |
| fault_page | output | 1 | Entry not valid |
| fault_prot | output | 1 | Ring or permission violation |
| irq_lvl14 | output | 1 | Status interrupt request for level 14 |

## Verification
The bench uses the default parameters: a 10-bit offset, an 8-bit physical page and a 2-bit table select. With these values the whole 256-entry table is small enough to fill completely from a fixed-seed random source and to mirror in the bench. As a result, random requests reach every table, every virtual page, all sixteen combinations of requesting ring and page ring, and every permission pattern. Directed cases cover the reserved access kind, the equal-ring boundary, idle cycles and a write that collides with a lookup.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // field offsets above the physical page number
  localparam int unsigned RD_OFS   = 0;
  localparam int unsigned WR_OFS   = 1;
  localparam int unsigned FX_OFS   = 2;
  localparam int unsigned RING_OFS = 3;
  localparam int unsigned RING_W   = 2;
  localparam int unsigned VLD_OFS  = 5;
  localparam int unsigned META_W   = 6;
endpackage

// File: rtl/mmu_page_table.sv
module mmu_page_table #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R2: a write is visible in storage after the edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
  import mmu_pkg::*;
#(
  parameter int unsigned PPN_W = 8,
  localparam int unsigned EW   = PPN_W + META_W
) (
  input  logic [EW-1:0]     entry,
  input  logic [1:0]        kind,
  input  logic [RING_W-1:0] ring,
  output logic              page_fault,
  output logic              prot_fault,
  output logic [PPN_W-1:0]  ppn
);
  localparam int unsigned RD_BIT  = PPN_W + RD_OFS;
  localparam int unsigned WR_BIT  = PPN_W + WR_OFS;
  localparam int unsigned FX_BIT  = PPN_W + FX_OFS;
  localparam int unsigned RING_LO = PPN_W + RING_OFS;
  localparam int unsigned VLD_BIT = PPN_W + VLD_OFS;

  logic              permit;
  logic [RING_W-1:0] page_ring;

  always_comb begin
    case (acc_kind_e'(kind))
      ACC_READ:  permit = entry[RD_BIT];
      ACC_WRITE: permit = entry[WR_BIT];
      ACC_FETCH: permit = entry[FX_BIT];
      default:   permit = 1'b0;
    endcase
  end

  assign page_ring  = entry[RING_LO +: RING_W];
  assign ppn        = entry[PPN_W-1:0];
  assign page_fault = ~entry[VLD_BIT];
  assign prot_fault = entry[VLD_BIT] & ((ring < page_ring) | ~permit);
endmodule

// File: rtl/mmu_ring_xlate.sv
module mmu_ring_xlate
  import mmu_pkg::*;
#(
  parameter int unsigned VA_W   = 16,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned PPN_W  = 8,
  parameter int unsigned TSEL_W = 2,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PA_W  = PPN_W + OFF_W,
  localparam int unsigned TA_W  = TSEL_W + VPN_W,
  localparam int unsigned EW    = PPN_W + META_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [RING_W-1:0] req_ring,
  input  logic [TSEL_W-1:0] req_tsel,
  input  logic              tbl_we,
  input  logic [TA_W-1:0]   tbl_waddr,
  input  logic [EW-1:0]     tbl_wdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              fault_page,
  output logic              fault_prot,
  output logic              irq_lvl14
);
  logic [TA_W-1:0]  lk_addr;
  logic [EW-1:0]    lk_entry;
  logic             chk_pf, chk_prf;
  logic [PPN_W-1:0] chk_ppn;

  assign lk_addr = {req_tsel, req_vaddr[VA_W-1:OFF_W]};

  mmu_page_table #(.AW(TA_W), .DW(EW)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (lk_addr),
    .rdata (lk_entry)
  );

  mmu_access_check #(.PPN_W(PPN_W)) u_chk (
    .entry      (lk_entry),
    .kind       (req_kind),
    .ring       (req_ring),
    .page_fault (chk_pf),
    .prot_fault (chk_prf),
    .ppn        (chk_ppn)
  );

  // next-state
  logic            vld_d, pf_d, prf_d, upd_en;
  logic [PA_W-1:0] pa_d;
  logic            vld_q, pf_q, prf_q;
  logic [PA_W-1:0] pa_q;

  always_comb begin
    vld_d = req_valid;
    pf_d  = req_valid & chk_pf;
    prf_d = req_valid & chk_prf;
    pa_d  = '0;
    if (req_valid && !chk_pf && !chk_prf) begin
      pa_d = {chk_ppn, req_vaddr[OFF_W-1:0]};
    end
    upd_en = req_valid | vld_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pf_q  <= 1'b0;
      prf_q <= 1'b0;
      pa_q  <= '0;
    end else if (upd_en) begin
      vld_q <= vld_d;
      pf_q  <= pf_d;
      prf_q <= prf_d;
      pa_q  <= pa_d;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_paddr  = pa_q;
  assign fault_page = pf_q;
  assign fault_prot = prf_q;
  assign irq_lvl14  = pf_q | prf_q;

  // R3: result follows request by one cycle
  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));
  // R3: offset passes through untranslated
  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !chk_pf && !chk_prf) |=> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
  // R8: the two faults never coincide
  p_fault_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_page && fault_prot));
  // R9: faults only accompany a response
  p_fault_needs_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_page || fault_prot) |-> rsp_valid);
  // R5: a faulting response carries no address
  p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_page || fault_prot) |-> rsp_paddr == '0);
endmodule

// File: tb/sim_mmu_ring_xlate.sv
module sim_mmu_ring_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_vaddr;
  logic [1:0]  req_kind, req_ring, req_tsel;
  logic        tbl_we;
  logic [7:0]  tbl_waddr;
  logic [13:0] tbl_wdata;
  logic        rsp_valid, fault_page, fault_prot, irq_lvl14;
  logic [17:0] rsp_paddr;

  int n_chk = 0;
  int n_bad = 0;
  logic [13:0] model [256];

  always #2 clk = ~clk;

  mmu_ring_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_ring(req_ring), .req_tsel(req_tsel),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .fault_page(fault_page),
    .fault_prot(fault_prot), .irq_lvl14(irq_lvl14)
  );

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: act=running exp=done");
    report();
  end

  task automatic chk(input string req, input logic [20:0] act, input logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected {valid, page fault, prot fault, paddr} from the requirements
  function automatic logic [20:0] predict(input logic [13:0] e, input logic [15:0] va,
                                         input logic [1:0] kind, input logic [1:0] ring);
    logic ok_perm;
    if (!e[13]) return {3'b110, 18'd0};                 // R5
    case (kind)
      2'd0: ok_perm = e[8];
      2'd1: ok_perm = e[9];
      2'd2: ok_perm = e[10];
      default: ok_perm = 1'b0;                          // R7 reserved kind
    endcase
    if (ring < e[12:11] || !ok_perm) return {3'b101, 18'd0};  // R6, R7
    return {3'b100, e[7:0], va[9:0]};                   // R3
  endfunction

  function automatic logic [20:0] outs();
    return {rsp_valid, fault_page, fault_prot, rsp_paddr};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [13:0] d);
    tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = d;
    @(posedge clk); #1;
    tbl_we = 1'b0;
    model[a] = d;
    @(negedge clk);
  endtask

  task automatic look(input string req, input logic [1:0] ts, input logic [15:0] va,
                      input logic [1:0] kind, input logic [1:0] ring);
    logic [20:0] exp;
    exp = predict(model[{ts, va[15:10]}], va, kind, ring);
    req_valid = 1'b1; req_tsel = ts; req_vaddr = va; req_kind = kind; req_ring = ring;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(req, outs(), exp);
    chk({req, " R8 irq"}, {20'd0, irq_lvl14}, {20'd0, exp[19] | exp[18]});
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_ring = '0;
    req_tsel = '0; tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {outs()[20:0]} | {20'd0, irq_lvl14}, 21'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after reset", outs() | {20'd0, irq_lvl14}, 21'd0);
    @(negedge clk);

    // R2: fill all four tables at random, about 80% valid
    for (int i = 0; i < 256; i++) begin
      logic [13:0] d;
      d = 14'($urandom);
      d[13] = ($urandom % 5) != 0;
      wr(8'(i), d);
    end

    // R4: same virtual page, four different tables
    for (int t = 0; t < 4; t++) begin
      wr({2'(t), 6'd5}, {1'b1, 2'd0, 3'b111, 8'(8'h40 + t)});
      look("R4 table select", 2'(t), 16'h1400 | 16'h0123, 2'd0, 2'd0);
    end

    // R5: invalid page for every kind and ring
    wr(8'h11, {1'b0, 2'd0, 3'b111, 8'hAA});
    look("R5 invalid page", 2'd0, {6'h11, 10'h3FF}, 2'd2, 2'd3);
    look("R5 invalid page", 2'd0, {6'h11, 10'h000}, 2'd0, 2'd0);

    // R6: ring boundary
    wr(8'h22, {1'b1, 2'd2, 3'b111, 8'h5C});
    look("R6 lower ring", 2'd0, {6'h22, 10'h010}, 2'd0, 2'd1);
    look("R6 equal ring", 2'd0, {6'h22, 10'h010}, 2'd0, 2'd2);
    look("R6 higher ring", 2'd0, {6'h22, 10'h010}, 2'd1, 2'd3);

    // R7: single permission bit per kind, plus reserved kind
    wr(8'h33, {1'b1, 2'd0, 3'b010, 8'h77});
    look("R7 write allowed", 2'd0, {6'h33, 10'h155}, 2'd1, 2'd0);
    look("R7 read refused", 2'd0, {6'h33, 10'h155}, 2'd0, 2'd3);
    look("R7 fetch refused", 2'd0, {6'h33, 10'h155}, 2'd2, 2'd3);
    wr(8'h34, {1'b1, 2'd0, 3'b111, 8'h78});
    look("R7 reserved kind", 2'd0, {6'h34, 10'h155}, 2'd3, 2'd3);

    // R9: idle cycle clears response
    @(posedge clk); #1;
    chk("R9 idle", outs() | {20'd0, irq_lvl14}, 21'd0);
    @(negedge clk);

    // R10: lookup collides with a write to the same entry
    wr(8'h40, {1'b1, 2'd0, 3'b111, 8'h01});
    begin
      logic [20:0] exp_old;
      exp_old = predict(model[8'h40], 16'h0007, 2'd0, 2'd0);
      req_valid = 1'b1; req_tsel = 2'd1; req_vaddr = 16'h0007; req_kind = 2'd0; req_ring = 2'd0;
      tbl_we = 1'b1; tbl_waddr = 8'h40; tbl_wdata = {1'b1, 2'd0, 3'b111, 8'hF0};
      @(posedge clk); #1;
      req_valid = 1'b0; tbl_we = 1'b0;
      model[8'h40] = {1'b1, 2'd0, 3'b111, 8'hF0};
      chk("R10 old contents", outs(), exp_old);
      @(negedge clk);
      look("R10 new contents", 2'd1, 16'h0007, 2'd0, 2'd0);
    end

    // R3 R6 R7 R8: random lookups against the mirrored table
    for (int k = 0; k < 3000; k++) begin
      look("R3 random", 2'($urandom), 16'($urandom), 2'($urandom), 2'($urandom));
      if ((k % 7) == 0) begin
        @(posedge clk); #1;
        chk("R9 random idle", outs() | {20'd0, irq_lvl14}, 21'd0);
        @(negedge clk);
      end
    end
    report();
  end
endmodule